// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps a record of loads that a scheduler has hoisted above stores that might write the same bytes. When such an early load issues, it records the address and width it read under its destination register number. Every later store is compared against all live records at once. Any record whose bytes overlap the store is dropped. Before the early-loaded value may be used, a check query asks whether the record for that register still exists. A hit means no store has touched those bytes, so the value stands. A miss means the load must be redone by recovery code outside this block.

The table has 32 records in 16 sets of 2 ways. The set is chosen by the low four bits of the 7-bit register number. A record keeps the upper register bits, the address of the 8-byte granule, and a byte mask. When a set is full, the victim is the way that was allocated least recently. A check returns its answer one cycle after it is issued. It can optionally remove the record it hits. A flush clears the whole table in one cycle, for example on a context switch.

Top module: `spec_load_table`

## Requirements
- R1: After reset, every record is invalid, `chk_done_o` and `chk_hit_o` are 0, and a check of any of the 128 register numbers misses.
- R2: A check issued in cycle N drives `chk_done_o`=1 in cycle N+1 and 0 otherwise. `chk_hit_o` is 1 only when a valid record exists for the queried register, and only when `chk_done_o` is 1.
- R3: A store removes a record only when two conditions hold: its address bits above bit 2 equal the record's, and its bytes overlap the record's bytes. Sizes are coded 0,1,2,3 for 1,2,4,8 bytes, and every access is naturally aligned. Records with disjoint bytes, or in another granule, stay valid.
- R4: The set index is register bits [3:0]. Each set holds two records. Allocating a third distinct register in a full set replaces the record allocated least recently.
- R5: A second allocation to a register that already has a record overwrites that record in place. The new address then governs matching, and the other way of the set is left alone.
- R6: When an allocation and a store in the same cycle overlap, the new record ends invalid. If they do not overlap, the new record is valid.
- R7: A hitting check with `chk_clear_i`=1 removes the record, so a later check misses. With `chk_clear_i`=0 the record stays.
- R8: `flush_i` invalidates all 32 records in one cycle. It overrides an allocation in the same cycle.
- R9: A check sees the table as it was before any store, allocation or flush in the same cycle.
- R10: Registers that share a set index but differ in bits [6:4] never match each other's record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate every record |
| alloc_valid_i | input | 1 | Early load allocates a record |
| alloc_reg_i | input | 7 | Destination register of the early load |
| alloc_addr_i | input | 32 | Byte address of the early load |
| alloc_size_i | input | 2 | Early load size code (0..3 = 1,2,4,8 bytes) |
| st_valid_i | input | 1 | Store searches the table |
| st_addr_i | input | 32 | Byte address of the store |
| st_size_i | input | 2 | Store size code |
| chk_valid_i | input | 1 | Check query issued |
| chk_reg_i | input | 7 | Register being checked |
| chk_clear_i | input | 1 | Remove the record if the check hits |
| chk_done_o | output | 1 | Check result valid (one cycle after the query) |
| chk_hit_o | output | 1 | Record was present |

## Verification
The checker watches, on every cycle, the timing of the check result, that a flush leaves no valid record, and that an allocation with no store or flush always leaves something valid. It also checks that a store alone, or a clearing check alone, never increases the number of valid records. Which record a store removes, which way is chosen as victim, and how overwrites, clears and same-cycle orderings resolve can only be shown by the bench's scenarios. These include a sweep over every aligned pair of load and store offsets and sizes within a granule, with overlap computed from byte ranges.

// File: rtl/specld_pkg.sv
// Shared helpers for the speculative load address tracker.
// Assumes accesses are naturally aligned inside one 8-byte granule.
package specld_pkg;

    localparam int GRAN_BYTES = 8;
    localparam int OFF_W      = 3;

    // Byte lanes touched by an access of 2**size bytes at the given offset.
    function automatic logic [GRAN_BYTES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                        input logic [1:0] size);
        logic [GRAN_BYTES-1:0] base;
        case (size)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            2'd2:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        return base << off;
    endfunction

endpackage

// File: rtl/specld_entry.sv
// One record of the tracker: valid flag, upper register bits, granule
// address and byte lanes. Resolves flush > write > (store hit | clear).
// Assumes the store comparison uses the contents held before this edge.
module specld_entry
    import specld_pkg::*;
#(
    parameter int HI_W   = 3,
    parameter int GRAN_W = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  wr_en_i,
    input  logic                  wr_live_i,
    input  logic [HI_W-1:0]       wr_hi_i,
    input  logic [GRAN_W-1:0]     wr_gran_i,
    input  logic [GRAN_BYTES-1:0] wr_mask_i,
    input  logic                  st_valid_i,
    input  logic [GRAN_W-1:0]     st_gran_i,
    input  logic [GRAN_BYTES-1:0] st_mask_i,
    input  logic                  clr_i,
    output logic                  valid_o,
    output logic [HI_W-1:0]       hi_o
);

    logic                  valid_q;
    logic [HI_W-1:0]       hi_q;
    logic [GRAN_W-1:0]     gran_q;
    logic [GRAN_BYTES-1:0] mask_q;
    logic                  st_hit;

    // Store aliases this record when granules match and lanes intersect.
    always_comb begin
        st_hit = st_valid_i && (st_gran_i == gran_q) && ((st_mask_i & mask_q) != '0);
    end

    // Record update with flush first, then new allocation, then removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hi_q    <= '0;
            gran_q  <= '0;
            mask_q  <= '0;
        end else if (flush_i) begin
            valid_q <= 1'b0;
        end else if (wr_en_i) begin
            valid_q <= wr_live_i;
            hi_q    <= wr_hi_i;
            gran_q  <= wr_gran_i;
            mask_q  <= wr_mask_i;
        end else if (st_hit || clr_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign hi_o    = hi_q;

endmodule

// File: rtl/specld_set.sv
// One set of the tracker. Picks the way for an allocation (same register,
// else lowest free way, else the least recently allocated way) and answers
// check lookups from the state held before the edge.
// Assumes at most one allocation and one check per cycle.
module specld_set
    import specld_pkg::*;
#(
    parameter int WAYS   = 2,
    parameter int HI_W   = 3,
    parameter int GRAN_W = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic                  alloc_en_i,
    input  logic                  alloc_live_i,
    input  logic [HI_W-1:0]       alloc_hi_i,
    input  logic [GRAN_W-1:0]     alloc_gran_i,
    input  logic [GRAN_BYTES-1:0] alloc_mask_i,
    input  logic                  st_valid_i,
    input  logic [GRAN_W-1:0]     st_gran_i,
    input  logic [GRAN_BYTES-1:0] st_mask_i,
    input  logic                  chk_en_i,
    input  logic [HI_W-1:0]       chk_hi_i,
    input  logic                  chk_clear_i,
    output logic                  chk_hit_o,
    output logic [WAYS-1:0]       valid_o
);

    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]       way_valid;
    logic [HI_W-1:0]       way_hi [WAYS];
    logic [WAYS-1:0]       alloc_match;
    logic [WAYS-1:0]       chk_match;
    logic [WAY_W-1:0]      victim_q;
    logic [WAY_W-1:0]      sel;

    // Tag comparison of every way for allocation and for check.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            alloc_match[w] = way_valid[w] && (way_hi[w] == alloc_hi_i);
            chk_match[w]   = way_valid[w] && (way_hi[w] == chk_hi_i);
        end
    end

    // Way choice: existing record, then first free way, then victim pointer.
    always_comb begin
        logic found;
        sel   = victim_q;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && alloc_match[w]) begin
                sel   = WAY_W'(w);
                found = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_valid[w]) begin
                sel   = WAY_W'(w);
                found = 1'b1;
            end
        end
    end

    // Victim pointer moves past the way just allocated.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            victim_q <= '0;
        end else if (alloc_en_i) begin
            victim_q <= (sel == WAY_W'(WAYS - 1)) ? '0 : sel + WAY_W'(1);
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        specld_entry #(
            .HI_W  (HI_W),
            .GRAN_W(GRAN_W)
        ) i_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush_i),
            .wr_en_i   (alloc_en_i && (sel == WAY_W'(w))),
            .wr_live_i (alloc_live_i),
            .wr_hi_i   (alloc_hi_i),
            .wr_gran_i (alloc_gran_i),
            .wr_mask_i (alloc_mask_i),
            .st_valid_i(st_valid_i),
            .st_gran_i (st_gran_i),
            .st_mask_i (st_mask_i),
            .clr_i     (chk_en_i && chk_clear_i && chk_match[w]),
            .valid_o   (way_valid[w]),
            .hi_o      (way_hi[w])
        );
    end

    assign chk_hit_o = chk_en_i && (chk_match != '0);
    assign valid_o   = way_valid;

endmodule

// File: rtl/spec_load_table.sv
// Speculative load address tracker, top level. Splits register numbers into
// set index and upper bits, splits addresses into granule and byte lanes,
// fans requests out to the sets and registers the check answer.
// Assumes naturally aligned accesses of 1, 2, 4 or 8 bytes.
module spec_load_table
    import specld_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 7,
    parameter int SET_W  = 4,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_valid_i,
    input  logic [REG_W-1:0]  alloc_reg_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [1:0]        alloc_size_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [1:0]        st_size_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              chk_clear_i,
    output logic              chk_done_o,
    output logic              chk_hit_o
);

    localparam int NUM_SETS = 2 ** SET_W;
    localparam int HI_W     = REG_W - SET_W;
    localparam int GRAN_W   = ADDR_W - OFF_W;
    localparam int ENTRIES  = NUM_SETS * WAYS;

    logic [SET_W-1:0]      alloc_idx;
    logic [HI_W-1:0]       alloc_hi;
    logic [GRAN_W-1:0]     alloc_gran;
    logic [GRAN_BYTES-1:0] alloc_mask;
    logic                  alloc_live;
    logic [SET_W-1:0]      chk_idx;
    logic [HI_W-1:0]       chk_hi;
    logic [GRAN_W-1:0]     st_gran;
    logic [GRAN_BYTES-1:0] st_mask;
    logic [NUM_SETS-1:0]   set_hit;
    logic [ENTRIES-1:0]    valid_flat;
    logic                  chk_done_q;
    logic                  chk_hit_q;

    // Field split of the request ports.
    always_comb begin
        alloc_idx  = alloc_reg_i[SET_W-1:0];
        alloc_hi   = alloc_reg_i[REG_W-1:SET_W];
        alloc_gran = alloc_addr_i[ADDR_W-1:OFF_W];
        alloc_mask = lane_mask(alloc_addr_i[OFF_W-1:0], alloc_size_i);
        chk_idx    = chk_reg_i[SET_W-1:0];
        chk_hi     = chk_reg_i[REG_W-1:SET_W];
        st_gran    = st_addr_i[ADDR_W-1:OFF_W];
        st_mask    = lane_mask(st_addr_i[OFF_W-1:0], st_size_i);
    end

    // A same-cycle overlapping store kills the record being written.
    always_comb begin
        alloc_live = !(st_valid_i && (st_gran == alloc_gran) && ((st_mask & alloc_mask) != '0));
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        specld_set #(
            .WAYS  (WAYS),
            .HI_W  (HI_W),
            .GRAN_W(GRAN_W)
        ) i_set (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_i),
            .alloc_en_i  (alloc_valid_i && (alloc_idx == SET_W'(s))),
            .alloc_live_i(alloc_live),
            .alloc_hi_i  (alloc_hi),
            .alloc_gran_i(alloc_gran),
            .alloc_mask_i(alloc_mask),
            .st_valid_i  (st_valid_i),
            .st_gran_i   (st_gran),
            .st_mask_i   (st_mask),
            .chk_en_i    (chk_valid_i && (chk_idx == SET_W'(s))),
            .chk_hi_i    (chk_hi),
            .chk_clear_i (chk_clear_i),
            .chk_hit_o   (set_hit[s]),
            .valid_o     (valid_flat[s*WAYS +: WAYS])
        );
    end

    // Check answer is registered one cycle after the query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_done_q <= 1'b0;
            chk_hit_q  <= 1'b0;
        end else begin
            chk_done_q <= chk_valid_i;
            chk_hit_q  <= set_hit != '0;
        end
    end

    assign chk_done_o = chk_done_q;
    assign chk_hit_o  = chk_hit_q;

endmodule

// File: rtl/specld_checker.sv
// Cycle-level properties of the speculative load address tracker.
// Sees the flattened record valid bits of the top level through bind.
module specld_checker #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               alloc_valid_i,
    input logic               st_valid_i,
    input logic               chk_valid_i,
    input logic               chk_clear_i,
    input logic               chk_done_o,
    input logic               chk_hit_o,
    input logic [ENTRIES-1:0] valid_flat
);

    AST_DONE_FOLLOWS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> chk_done_o); // R2
    AST_NO_DONE_WITHOUT_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |=> !chk_done_o); // R2
    AST_HIT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit_o |-> chk_done_o); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_flat == '0)); // R8
    AST_ALLOC_LEAVES_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !flush_i && !st_valid_i) |=> (valid_flat != '0)); // R6
    AST_STORE_NEVER_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && !alloc_valid_i) |=>
        ($countones(valid_flat) <= $past($countones(valid_flat)))); // R3
    AST_CLEAR_NEVER_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid_i && chk_clear_i && !alloc_valid_i) |=>
        ($countones(valid_flat) <= $past($countones(valid_flat)))); // R7

endmodule

bind spec_load_table specld_checker #(.ENTRIES(ENTRIES)) i_specld_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .alloc_valid_i(alloc_valid_i),
    .st_valid_i   (st_valid_i),
    .chk_valid_i  (chk_valid_i),
    .chk_clear_i  (chk_clear_i),
    .chk_done_o   (chk_done_o),
    .chk_hit_o    (chk_hit_o),
    .valid_flat   (valid_flat)
);

// File: tb/test_spec_load_table.sv
// Directed scenarios and an aligned overlap sweep for the tracker.
module test_spec_load_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        alloc_valid_i = 1'b0;
    logic [6:0]  alloc_reg_i = '0;
    logic [31:0] alloc_addr_i = '0;
    logic [1:0]  alloc_size_i = '0;
    logic        st_valid_i = 1'b0;
    logic [31:0] st_addr_i = '0;
    logic [1:0]  st_size_i = '0;
    logic        chk_valid_i = 1'b0;
    logic [6:0]  chk_reg_i = '0;
    logic        chk_clear_i = 1'b0;
    logic        chk_done_o;
    logic        chk_hit_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    spec_load_table i_spec_load_table (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .alloc_valid_i(alloc_valid_i), .alloc_reg_i(alloc_reg_i),
        .alloc_addr_i(alloc_addr_i), .alloc_size_i(alloc_size_i),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
        .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i), .chk_clear_i(chk_clear_i),
        .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change right after a falling edge; one rising edge acts on them.
    task automatic set_alloc(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
        alloc_valid_i = 1'b1; alloc_reg_i = r; alloc_addr_i = a; alloc_size_i = s;
    endtask

    task automatic set_store(input logic [31:0] a, input logic [1:0] s);
        st_valid_i = 1'b1; st_addr_i = a; st_size_i = s;
    endtask

    task automatic set_check(input logic [6:0] r, input logic c);
        chk_valid_i = 1'b1; chk_reg_i = r; chk_clear_i = c;
    endtask

    task automatic step();
        @(negedge clk);
        alloc_valid_i = 1'b0; st_valid_i = 1'b0; chk_valid_i = 1'b0;
        chk_clear_i = 1'b0; flush_i = 1'b0;
    endtask

    task automatic do_alloc(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
        set_alloc(r, a, s); step();
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] s);
        set_store(a, s); step();
    endtask

    task automatic do_flush();
        flush_i = 1'b1; step();
    endtask

    // Result is registered at the edge after the query; sampled at the next fall.
    task automatic expect_chk(input logic [6:0] r, input logic c, input bit exp, input string req);
        set_check(r, c); step();
        check(chk_done_o === 1'b1 && chk_hit_o === exp, req, int'(chk_hit_o), int'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(chk_done_o === 1'b0 && chk_hit_o === 1'b0, "R1 reset outputs",
              int'(chk_done_o), 0);
        rst_n = 1'b1;
        step();
        // R1: every register misses after reset
        for (int r = 0; r < 128; r++) expect_chk(7'(r), 1'b0, 1'b0, "R1 empty after reset");
        // R2: no result without a query
        step();
        check(chk_done_o === 1'b0, "R2 idle done", int'(chk_done_o), 0);

        // R2: allocate then check hits
        do_alloc(7'd5, 32'h100, 2'd2);
        expect_chk(7'd5, 1'b0, 1'b1, "R2 hit after alloc");

        // R3: sweep every aligned load/store pair inside a granule
        for (int ls = 0; ls < 4; ls++) begin
            for (int lo = 0; lo < 8; lo += (1 << ls)) begin
                for (int ss = 0; ss < 4; ss++) begin
                    for (int so = 0; so < 8; so += (1 << ss)) begin
                        int lb = 32'h1000 + lo;
                        int sb = 32'h1000 + so;
                        bit ovl = (lb < sb + (1 << ss)) && (sb < lb + (1 << ls));
                        do_flush();
                        do_alloc(7'd5, 32'(lb), 2'(ls));
                        do_store(32'(sb), 2'(ss));
                        expect_chk(7'd5, 1'b0, !ovl, "R3 overlap sweep");
                    end
                end
            end
        end
        // R3: same offsets in the next granule do not alias
        do_flush();
        do_alloc(7'd5, 32'h1000, 2'd3);
        do_store(32'h1008, 2'd3);
        expect_chk(7'd5, 1'b0, 1'b1, "R3 other granule");

        // R4/R3: fill all 32 records, one store removes only reg 7
        do_flush();
        for (int r = 0; r < 32; r++) do_alloc(7'(r), 32'h2000 + 32'(8 * r), 2'd3);
        do_store(32'h2000 + 32'(8 * 7) + 32'd3, 2'd0);
        for (int r = 0; r < 32; r++) expect_chk(7'(r), 1'b0, r != 7, "R4 full table, R3 single kill");

        // R4: third register in a set replaces the oldest allocation
        do_flush();
        do_alloc(7'd1,  32'h3000, 2'd3);
        do_alloc(7'd17, 32'h3008, 2'd3);
        do_alloc(7'd33, 32'h3010, 2'd3);
        expect_chk(7'd1,  1'b0, 1'b0, "R4 oldest evicted");
        expect_chk(7'd17, 1'b0, 1'b1, "R4 survivor");
        expect_chk(7'd33, 1'b0, 1'b1, "R4 newcomer");
        do_alloc(7'd49, 32'h3018, 2'd3);
        expect_chk(7'd17, 1'b0, 1'b0, "R4 next oldest evicted");
        expect_chk(7'd33, 1'b0, 1'b1, "R4 kept");

        // R5: reallocation overwrites in place
        do_flush();
        do_alloc(7'd2,  32'h4000, 2'd3);
        do_alloc(7'd18, 32'h4100, 2'd3);
        do_alloc(7'd2,  32'h4200, 2'd3);
        expect_chk(7'd18, 1'b0, 1'b1, "R5 other way untouched");
        do_store(32'h4000, 2'd3);
        expect_chk(7'd2, 1'b0, 1'b1, "R5 old address no longer matches");
        do_store(32'h4204, 2'd1);
        expect_chk(7'd2, 1'b0, 1'b0, "R5 new address matches");

        // R6: allocation and store in the same cycle
        do_flush();
        set_alloc(7'd4, 32'h5000, 2'd2); set_store(32'h5002, 2'd0); step();
        expect_chk(7'd4, 1'b0, 1'b0, "R6 overlapping same cycle");
        set_alloc(7'd4, 32'h5000, 2'd2); set_store(32'h5004, 2'd2); step();
        expect_chk(7'd4, 1'b0, 1'b1, "R6 disjoint same cycle");

        // R7: clearing and non-clearing checks
        do_alloc(7'd3, 32'h6000, 2'd0);
        expect_chk(7'd3, 1'b1, 1'b1, "R7 clearing hit");
        expect_chk(7'd3, 1'b0, 1'b0, "R7 cleared");
        do_alloc(7'd3, 32'h6000, 2'd0);
        expect_chk(7'd3, 1'b0, 1'b1, "R7 keep hit");
        expect_chk(7'd3, 1'b0, 1'b1, "R7 still present");

        // R9: check sees state before a same-cycle store
        do_alloc(7'd9, 32'h7000, 2'd3);
        set_check(7'd9, 1'b0); set_store(32'h7000, 2'd3); step();
        check(chk_done_o === 1'b1 && chk_hit_o === 1'b1, "R9 pre-state hit", int'(chk_hit_o), 1);
        expect_chk(7'd9, 1'b0, 1'b0, "R9 removed afterwards");

        // R10: same index, different upper bits
        do_flush();
        do_alloc(7'd2, 32'h8000, 2'd3);
        expect_chk(7'd18,  1'b0, 1'b0, "R10 alias 18");
        expect_chk(7'd34,  1'b0, 1'b0, "R10 alias 34");
        expect_chk(7'd114, 1'b0, 1'b0, "R10 alias 114");
        expect_chk(7'd2,   1'b0, 1'b1, "R10 owner");

        // R8: flush wins over same-cycle allocation
        for (int r = 0; r < 32; r++) do_alloc(7'(r), 32'h9000 + 32'(8 * r), 2'd3);
        flush_i = 1'b1; set_alloc(7'd40, 32'hA000, 2'd3); step();
        for (int r = 0; r < 32; r++) expect_chk(7'(r), 1'b0, 1'b0, "R8 flushed");
        expect_chk(7'd40, 1'b0, 1'b0, "R8 flush beats alloc");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule